// File: doc/BRIEF.md
# Hybrid Dedicated/Shared Product-Term Logic Array

This block is a configurable sum-of-products array that sits in front of a bank of macrocells. Every one of its 16 outputs is the OR of two groups of product terms. The first group is five private terms that belong to that output alone. The second group is any subset of a pool of 32 shared terms, picked by a fully programmable OR plane. One shared term can feed any number of outputs at once, so logic common to several outputs is built only once. A single output can use all 37 of the terms it can reach.

Each product term is an AND over a selectable set of true and complemented literals of the 36-bit logic input. The whole configuration image is loaded through a one-bit serial shift chain and committed with a load strobe. While the image is being shifted in, and until a load with exactly the right bit count commits it, every output is held at 0. The outputs are purely combinational in the logic input. The logic path is the same for every output, whatever number of shared terms it selects.

Top module: `sop_hybrid_array`

## Requirements
- R1: After synchronous reset (rst high at a clock edge) every bit of dout is 0, and it stays 0 for any din until a valid load commits an image.
- R2: While cfg_shift is high at a clock edge, cfg_sdi is shifted into the chain. The image is 8688 bits long and its bit 0 is shifted in first. Term t occupies bits 73t..73t+72: offset 0 is the term enable, offset 1+i selects the true literal of din[i], and offset 37+i selects the complement literal of din[i]. The OR-plane bit at 8176+32o+p routes shared term p to output o.
- R3: A clock edge with cfg_load high and cfg_shift low commits the image only if exactly 8688 shift edges came since the last reset or load edge. With any other count (fewer or more) the outputs stay 0. Every load edge restarts the count.
- R4: Any shift edge withdraws the committed image: dout is 0 from the next edge until the next valid load.
- R5: An enabled term is 1 exactly when din[i] is 1 for every selected true literal and din[i] is 0 for every selected complement literal.
- R6: An enabled term with no literals selected is constant 1. A term whose enable bit is 0 is constant 0, whatever its literal bits. A term that selects both the true and the complement literal of one input is constant 0.
- R7: Terms 0..79 are dedicated: output o ORs terms 5o..5o+4, and a dedicated term has no effect on any other output.
- R8: Terms 80..111 form the shared pool (pool term p is term 80+p). A pool term reaches output o only when its OR-plane bit is 1, and one pool term may drive several outputs at the same time.
- R9: dout follows din combinationally, with no clock edge in between, including for an output that uses all 5 dedicated and all 32 shared terms.
- R10: When cfg_shift and cfg_load are both high at one edge, only the shift takes place: the image is not committed and the bit still counts toward the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one configuration bit in on this edge |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Commit the shifted image on this edge |
| din | input | 36 | Logic input vector |
| dout | output | 16 | One sum-of-products result per output |

## Verification
The hardest situations to reach from the ports are the boundaries of the configuration protocol. These are a load that comes one bit short or one bit over, a load after a single stray shift, and a final bit shifted in with both strobes high. Each needs a full 8688-bit serial transfer, so the bench builds images in software and streams them with deliberately wrong lengths and strobe overlaps. A second image wires all 37 terms of one output, puts contradictory and empty terms on other outputs, and has one shared term feeding two outputs. Directed input vectors then tell the dedicated paths and the shared paths apart.

// File: rtl/sop_pkg.sv
package sop_pkg;

    parameter int N_IN   = 36;
    parameter int N_OUT  = 16;
    parameter int N_PAL  = 5;
    parameter int N_POOL = 32;

    localparam int TERM_W    = 1 + 2 * N_IN;
    localparam int N_DED     = N_OUT * N_PAL;
    localparam int N_TERMS   = N_DED + N_POOL;
    localparam int AND_W     = N_TERMS * TERM_W;
    localparam int OR_W      = N_OUT * N_POOL;
    localparam int CFG_W     = AND_W + OR_W;
    localparam int OR_BASE   = AND_W;
    localparam int POOL_BASE = N_DED;

    // One product term of the AND plane; field order fixes the image layout.
    typedef struct packed {
        logic [N_IN-1:0] comp_sel;
        logic [N_IN-1:0] true_sel;
        logic            en;
    } term_cfg_t;

    // A term is true when no selected literal is violated by the input.
    function automatic logic term_value(term_cfg_t c, logic [N_IN-1:0] x);
        logic [N_IN-1:0] miss;
        miss = (c.true_sel & ~x) | (c.comp_sel & x);
        return c.en & ~(|miss);
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain
    import sop_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         sdi_i,
    input  logic         load_i,
    output logic [W-1:0] image_o,
    output logic         active_o
);

    localparam int              CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(W + 1);

    logic [W-1:0]     chain;
    logic [CNT_W-1:0] cnt;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (shift_i) begin
            chain  <= {sdi_i, chain[W-1:1]};
            active <= 1'b0;
            if (cnt != OVER) cnt <= cnt + 1'b1;
        end else if (load_i) begin
            active <= (cnt == FULL);
            cnt    <= '0;
        end
    end

    assign image_o  = chain;
    assign active_o = active;

    a_r4_shift_withdraws: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> !active_o);

    a_r2_bit_enters_top: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (chain[W-1] == $past(sdi_i)));

    a_r3_exact_count_commits: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && load_i && cnt == FULL) |=> active_o);

    a_r3_wrong_count_rejected: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && load_i && cnt != FULL) |=> !active_o);

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= OVER);

    a_r10_overlap_no_commit: assert property (@(posedge clk) disable iff (rst)
        (shift_i && load_i) |=> (!active_o && cnt != '0));

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval
    import sop_pkg::*;
(
    input  term_cfg_t       cfg_i,
    input  logic [N_IN-1:0] din_i,
    output logic            hit_o
);

    always_comb begin
        hit_o = term_value(cfg_i, din_i);
    end

endmodule

// File: rtl/sop_or_select.sv
module sop_or_select
    import sop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic [N_PAL-1:0]  pal_i,
    input  logic [N_POOL-1:0] pool_i,
    input  logic [N_POOL-1:0] sel_i,
    output logic              out_o
);

    logic [N_POOL-1:0] routed;
    logic              ded_any;
    logic              pool_any;

    // Full-width reduction: depth does not depend on how many selects are set.
    always_comb begin
        routed   = pool_i & sel_i;
        ded_any  = |pal_i;
        pool_any = |routed;
        out_o    = active_i & (ded_any | pool_any);
    end

    a_r1_idle_output_low: assert property (@(posedge clk) disable iff (rst)
        !active_i |-> !out_o);

    a_r7_dedicated_drives: assert property (@(posedge clk) disable iff (rst)
        (active_i && pal_i != '0) |-> out_o);

    a_r8_routed_pool_drives: assert property (@(posedge clk) disable iff (rst)
        (active_i && (pool_i & sel_i) != '0) |-> out_o);

endmodule

// File: rtl/sop_hybrid_array.sv
module sop_hybrid_array
    import sop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift,
    input  logic             cfg_sdi,
    input  logic             cfg_load,
    input  logic [N_IN-1:0]  din,
    output logic [N_OUT-1:0] dout
);

    logic [CFG_W-1:0]   image;
    logic               active;
    logic [N_TERMS-1:0] term_hit;

    sop_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_i  (cfg_shift),
        .sdi_i    (cfg_sdi),
        .load_i   (cfg_load),
        .image_o  (image),
        .active_o (active)
    );

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        term_cfg_t tcfg;
        assign tcfg = image[t*TERM_W +: TERM_W];
        sop_term_eval u_term (
            .cfg_i (tcfg),
            .din_i (din),
            .hit_o (term_hit[t])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        sop_or_select u_sum (
            .clk      (clk),
            .rst      (rst),
            .active_i (active),
            .pal_i    (term_hit[o*N_PAL +: N_PAL]),
            .pool_i   (term_hit[POOL_BASE +: N_POOL]),
            .sel_i    (image[OR_BASE + o*N_POOL +: N_POOL]),
            .out_o    (dout[o])
        );
    end

    a_r1_quiet_until_loaded: assert property (@(posedge clk) disable iff (rst)
        !active |-> (dout == '0));

    a_r4_quiet_after_shift: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |=> (dout == '0));

endmodule

// File: tb/sim_sop_hybrid_array.sv
`timescale 1ns/1ps
module sim_sop_hybrid_array;
    import sop_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_shift = 1'b0;
    logic             cfg_sdi = 1'b0;
    logic             cfg_load = 1'b0;
    logic [N_IN-1:0]  din = '0;
    logic [N_OUT-1:0] dout;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    finished = 0;

    bit [CFG_W-1:0] img;
    bit [CFG_W-1:0] act;
    bit             m_valid = 0;
    bit             sent_q[$];

    always #5 clk = ~clk;

    sop_hybrid_array u0 (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
        .cfg_load(cfg_load), .din(din), .dout(dout)
    );

    // Behavioural model of the configuration protocol.
    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0;
            sent_q.delete();
        end else if (cfg_shift) begin
            m_valid = 0;
            sent_q.push_back(cfg_sdi);
        end else if (cfg_load) begin
            if (sent_q.size() == CFG_W) begin
                for (int i = 0; i < CFG_W; i++) act[i] = sent_q[i];
                m_valid = 1;
            end else begin
                m_valid = 0;
            end
            sent_q.delete();
        end
    end

    function automatic bit model_term(int t);
        int b;
        b = t * TERM_W;
        if (!act[b]) return 0;
        for (int i = 0; i < N_IN; i++) begin
            if (act[b + 1 + i] && !din[i]) return 0;
            if (act[b + 1 + N_IN + i] && din[i]) return 0;
        end
        return 1;
    endfunction

    function automatic logic [N_OUT-1:0] model_out();
        logic [N_OUT-1:0] r;
        r = '0;
        if (!m_valid) return r;
        for (int o = 0; o < N_OUT; o++) begin
            for (int k = 0; k < N_PAL; k++)
                if (model_term(o * N_PAL + k)) r[o] = 1'b1;
            for (int p = 0; p < N_POOL; p++)
                if (act[OR_BASE + o * N_POOL + p] && model_term(N_DED + p)) r[o] = 1'b1;
        end
        return r;
    endfunction

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [N_OUT-1:0] exp_v;
            exp_v = model_out();
            n_checks++;
            if (dout !== exp_v) begin
                n_fails++;
                $display("FAIL %s: dout=%h expected %h at %0t", cur_req, dout, exp_v, $time);
            end
        end
    end

    task automatic check_eq(string req, logic [N_OUT-1:0] got, logic [N_OUT-1:0] exp_v);
        n_checks++;
        if (got !== exp_v) begin
            n_fails++;
            $display("FAIL %s: dout=%h expected %h at %0t", req, got, exp_v, $time);
        end
    endtask

    task automatic set_term(int t, bit en, logic [N_IN-1:0] tr, logic [N_IN-1:0] cp);
        int b;
        b = t * TERM_W;
        img[b] = en;
        for (int i = 0; i < N_IN; i++) begin
            img[b + 1 + i]        = tr[i];
            img[b + 1 + N_IN + i] = cp[i];
        end
    endtask

    function automatic logic [N_IN-1:0] rnd_in();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [N_IN-1:0] sparse_in();
        return rnd_in() & rnd_in() & rnd_in() & rnd_in();
    endfunction

    // Streams count bits; positions below zero or past the image send 0.
    task automatic stream(int first, int count, bit overlap_last);
        for (int i = 0; i < count; i++) begin
            int idx;
            idx = first + i;
            @(posedge clk); #2;
            cfg_shift = 1'b1;
            cfg_sdi   = (idx >= 0 && idx < CFG_W) ? img[idx] : 1'b0;
            cfg_load  = (overlap_last && i == count - 1);
        end
        @(posedge clk); #2;
        cfg_shift = 1'b0;
        cfg_load  = 1'b0;
    endtask

    task automatic pulse_load();
        @(posedge clk); #2;
        cfg_load = 1'b1;
        @(posedge clk); #2;
        cfg_load = 1'b0;
    endtask

    task automatic apply(logic [N_IN-1:0] v);
        @(posedge clk); #2;
        din = v;
    endtask

    task automatic build_random_image();
        img = '0;
        for (int t = 0; t < N_TERMS; t++) begin
            logic [N_IN-1:0] tr, cp;
            tr = sparse_in();
            cp = sparse_in() & ~tr;
            set_term(t, ($urandom % 5) != 0, tr, cp);
        end
        for (int j = 0; j < OR_W; j++) img[OR_BASE + j] = (($urandom % 4) == 0);
    endtask

    task automatic build_corner_image();
        logic [N_IN-1:0] z;
        z = '0;
        for (int o = 0; o < 7; o++) begin
            for (int k = 0; k < N_PAL; k++) set_term(o * N_PAL + k, 0, z, z);
            for (int p = 0; p < N_POOL; p++) img[OR_BASE + o * N_POOL + p] = 0;
        end
        for (int p = 0; p < N_POOL; p++) set_term(N_DED + p, 1, N_IN'(1) << p, z);
        // Output 0: every dedicated and every pool term used, giving |din.
        for (int k = 0; k < 4; k++) set_term(k, 1, N_IN'(1) << (32 + k), z);
        set_term(4, 1, N_IN'(3) << 32, z);
        for (int p = 0; p < N_POOL; p++) img[OR_BASE + p] = 1;
        // Output 1: enabled empty term.
        set_term(1 * N_PAL, 1, z, z);
        // Output 2: contradictory term on input 3.
        set_term(2 * N_PAL, 1, N_IN'(1) << 3, N_IN'(1) << 3);
        // Outputs 3 and 4 share pool term 5.
        img[OR_BASE + 3 * N_POOL + 5] = 1;
        img[OR_BASE + 4 * N_POOL + 5] = 1;
        // Output 5: din[35] & ~din[34].
        set_term(5 * N_PAL + 2, 1, N_IN'(1) << 35, N_IN'(1) << 34);
        // Output 6: disabled term carrying a literal.
        set_term(6 * N_PAL + 1, 0, N_IN'(1), z);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [N_IN-1:0] ones;
        logic [6:0]      lo;
        ones = '1;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;

        cur_req = "R1";
        check_eq("R1", dout, '0);
        for (int i = 0; i < 10; i++) apply(rnd_in());
        apply(ones); #1 check_eq("R1", dout, '0);

        // Random image, exact length: exercises layout and evaluation.
        build_random_image();
        cur_req = "R2";
        stream(0, CFG_W, 0);
        pulse_load();
        cur_req = "R5 R7 R8";
        for (int i = 0; i < 150; i++) apply(rnd_in());
        for (int i = 0; i < 100; i++) apply(sparse_in());
        for (int i = 0; i < N_IN; i++) apply(N_IN'(1) << i);
        for (int i = 0; i < N_IN; i++) apply(~(N_IN'(1) << i));
        apply('0); apply(ones);

        // A single stray shift withdraws the image; a load after it is short.
        cur_req = "R4";
        stream(0, 1, 0);
        apply(ones); #1 check_eq("R4", dout, '0);
        cur_req = "R3";
        pulse_load();
        apply(ones); #1 check_eq("R3", dout, '0);

        // Corner image streamed one bit short.
        build_corner_image();
        stream(1, CFG_W - 1, 0);
        pulse_load();
        apply(ones); #1 check_eq("R3", dout, '0);

        // Full stream with both strobes high on the last bit, then a lone load.
        cur_req = "R10";
        stream(0, CFG_W, 1);
        apply(ones); #1 check_eq("R10", dout, '0);
        pulse_load();
        cur_req = "R6 R8";
        apply('0); #1 lo = dout[6:0];
        check_eq("R6", {9'd0, lo}, 16'h0002);
        apply(N_IN'(1) << 5); #1 lo = dout[6:0];
        check_eq("R8", {9'd0, lo}, 16'h001B);
        apply(N_IN'(1) << 20); #1 lo = dout[6:0];
        check_eq("R8", {9'd0, lo}, 16'h0003);
        apply(N_IN'(1) << 35); #1 lo = dout[6:0];
        check_eq("R7", {9'd0, lo}, 16'h0023);
        apply(N_IN'(3) << 34); #1 lo = dout[6:0];
        check_eq("R5", {9'd0, lo}, 16'h0003);
        apply(N_IN'(1)); #1 lo = dout[6:0];
        check_eq("R6", {9'd0, lo}, 16'h0003);
        apply(N_IN'(1) << 3); #1 lo = dout[6:0];
        check_eq("R6", {9'd0, lo}, 16'h0003);

        // Mid-cycle input change with no clock edge in between.
        cur_req = "R9";
        apply('0);
        @(negedge clk); #1 din = N_IN'(1) << 33;
        #1 check_eq("R9", {15'd0, dout[0]}, 16'h0001);
        #1 din = '0;
        #1 check_eq("R9", {15'd0, dout[0]}, 16'h0000);
        for (int i = 0; i < 60; i++) apply(rnd_in());

        // One bit too many before the load.
        cur_req = "R3";
        stream(-1, CFG_W + 1, 0);
        pulse_load();
        apply(ones); #1 check_eq("R3", dout, '0);
        for (int i = 0; i < 5; i++) apply(rnd_in());

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule